// File: doc/BRIEF.md
# Source-ID Context Resolver

This block turns the 16-bit source ID of an incoming DMA request into the translation context that later stages need. It does this by walking two tables in memory. It first reads a 16-byte entry from a root table, chosen by the bus number. It then reads a 16-byte entry from the context table that the root entry points to, chosen by the device/function number. Each table read is a single 128-bit read on a simple request/response memory port. Only one read is outstanding at a time.

The context entry is decoded into one of three results. A walk result gives the domain, the number of paging levels and the page-table pointer, and is handed to a downstream page walker. A pass-through result gives the page-aligned input address, the full length and all permissions. A fault result carries a reason code and a formatted 128-bit fault record. A suppression flag in the context entry lets software complete a faulting request quietly, without a fault record.

The block handles one request at a time. `req_ready` is high only while the block is idle. Every accepted request produces exactly one single-cycle pulse on `res_valid`.

Top module: `ctxres_top`

## Requirements
- R1: The root entry is read at `root_base + sid[15:8]*16`. The context entry is then read at `{root[63:12],12'h000} + sid[7:0]*16`. An entry's low qword is data bits 63:0 and its high qword is bits 127:64.
- R2: The root entry must have bit 0 set, or the request faults with reason 1. A present root entry with any of low bits 11:1 or high-qword bits set faults with reason 2. After a root fault no context read is issued.
- R3: Presence of the context entry (low bit 0) is checked first. An absent entry faults with reason 3 whatever its reserved bits hold. A present entry with any of low bits 11:4, high bits 7:3 or high bits 63:24 set faults with reason 4.
- R4: Context low bit 1 is the suppression flag. When it is set, any fault found at the context stage still completes with `res_kind`=2 and its reason, but `flt_valid` stays low.
- R5: Context low bits 3:2 select the kind of translation: 0 means page walk and 2 means pass-through. Values 1 and 3 fault with reason 5.
- R6: Only untranslated requests (`req_atype`=0) may walk or pass through. `req_atype` 1 (translation request) or 2 (translated) faults with reason 7.
- R7: Context high bits 2:0 give the address width. Codes 1, 2 and 3 give 3, 4 and 5 paging levels. Any other code faults with reason 6 and gives no walk result.
- R8: A walk result has `res_kind`=0, the domain from high bits 23:8, the levels from R7, and `res_table`=`{low[63:12],12'h000}`. `res_valid` is a single-cycle pulse.
- R9: Pass-through requires `pt_en`; without it the request faults with reason 5. A pass-through result has `res_kind`=1, `res_addr`=`req_addr` with bits 11:0 cleared, `res_len`=`req_len` and `res_perm`=3'b111.
- R10: The fault record high word holds the following fields: sid in [15:0], reason in [23:16], `req_type[0]` in [24], `req_type[1]` in [25], exec in [26], priv in [27], PASID-valid in [28], PASID in [48:29], zeros in [62:49] and a 1 in [63]. The low word is `req_addr` with bits 11:0 cleared. `flt_valid` implies `res_valid` with `res_kind`=2.
- R11: `req_ready` is high only when the block is idle. A `req_valid` asserted while the block is busy is ignored. Each accepted request yields exactly one result and at most two memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | ADDR_W | Base address of the root table |
| pt_en | input | 1 | Pass-through capability enable |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, a request can be accepted |
| req_sid | input | 16 | Source ID: bus in [15:8], device/function in [7:0] |
| req_addr | input | ADDR_W | DMA input address |
| req_len | input | LEN_W | Access length in bytes |
| req_type | input | 2 | Request-type bits, copied into the fault record |
| req_exec | input | 1 | Execute-request flag |
| req_priv | input | 1 | Privileged-request flag |
| req_atype | input | 2 | Address type: 0 untranslated, 1 translation request, 2 translated |
| req_pasid_v | input | 1 | PASID valid |
| req_pasid | input | 20 | PASID value |
| mem_req_valid | output | 1 | Table read request, one cycle |
| mem_req_addr | output | ADDR_W | Table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Entry data, low qword in [63:0] |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | 0 walk, 1 pass-through, 2 fault |
| res_reason | output | 4 | Fault reason code (0 when not a fault) |
| res_domain | output | 16 | Domain ID |
| res_levels | output | 3 | Paging levels |
| res_table | output | ADDR_W | Page-table pointer |
| res_addr | output | ADDR_W | Pass-through output address |
| res_len | output | LEN_W | Pass-through length |
| res_perm | output | 3 | Pass-through permissions {exec, write, read} |
| flt_valid | output | 1 | A fault record is emitted |
| flt_hi | output | 64 | Fault record high word |
| flt_lo | output | ADDR_W | Fault record low word |

## Verification
The assertions check, on every cycle, the properties that hold whatever the table contents are. They check that `req_ready` falls after an accept and is never high while a read is in flight. They check that results are single pulses and that walk results only carry 3 to 5 levels. They check that a root fault is never followed by a context read, that `flt_valid` only comes with a fault result, and that a suppressed context-stage fault never raises it. Only the bench scenarios can show the parts that depend on specific entry contents: the exact read addresses, the order of the presence, reserved-bit, type, address-type and width checks, the decoded domain and pointer values, the pass-through outputs, and the bit layout of the fault record.

// File: rtl/ctxres_pkg.sv
// Package: shared widths, result kinds, fault reasons and FSM states for the
// source-ID context resolver. Assumes 128-bit table entries and 16-bit source IDs.
package ctxres_pkg;
    localparam int ENTRY_W = 128;
    localparam int QW      = 64;
    localparam int SID_W   = 16;
    localparam int DOM_W   = 16;
    localparam int PASID_W = 20;
    localparam int PAGE_SH = 12;

    typedef enum logic [1:0] {
        KIND_WALK  = 2'd0,
        KIND_PASS  = 2'd1,
        KIND_FAULT = 2'd2
    } kind_e;

    typedef enum logic [3:0] {
        RSN_NONE        = 4'd0,
        RSN_ROOT_ABSENT = 4'd1,
        RSN_ROOT_RSVD   = 4'd2,
        RSN_CTX_ABSENT  = 4'd3,
        RSN_CTX_RSVD    = 4'd4,
        RSN_BAD_TYPE    = 4'd5,
        RSN_BAD_WIDTH   = 4'd6,
        RSN_BLOCKED     = 4'd7
    } reason_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROOT_RD, ST_ROOT_WAIT, ST_CTX_RD, ST_CTX_WAIT
    } state_e;

    typedef struct packed {
        kind_e              kind;
        reason_e            reason;
        logic               quiet;
        logic [DOM_W-1:0]   domain;
        logic [2:0]         levels;
    } verdict_t;
endpackage

// File: rtl/ctxres_root_chk.sv
// Root stage: forms the root entry address from the table base and bus number,
// checks presence and reserved bits of the returned entry, and forms the
// context entry address. Purely combinational; assumes ADDR_W <= 64.
module ctxres_root_chk
    import ctxres_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [SID_W-1:0]   sid,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ADDR_W-1:0]  root_addr,
    output logic [ADDR_W-1:0]  ctx_addr,
    output logic               present,
    output logic               rsvd_err
);
    localparam int IDX_SH = 4; // 16-byte entries

    logic [QW-1:0] ctx_base;

    // Address arithmetic and field checks for the root entry.
    always_comb begin
        root_addr = base + (ADDR_W'(sid[15:8]) << IDX_SH);
        ctx_base  = {entry[QW-1:PAGE_SH], {PAGE_SH{1'b0}}};
        ctx_addr  = ADDR_W'(ctx_base) + (ADDR_W'(sid[7:0]) << IDX_SH);
        present   = entry[0];
        rsvd_err  = (|entry[PAGE_SH-1:1]) || (|entry[ENTRY_W-1:QW]);
    end
endmodule

// File: rtl/ctxres_ctx_chk.sv
// Context stage: decodes a context entry into a verdict. Checks run in a fixed
// order: presence, reserved bits, translation kind (with pass-through enable),
// address type, then address width. Purely combinational.
module ctxres_ctx_chk
    import ctxres_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [1:0]         atype,
    input  logic               pt_en,
    output verdict_t           verdict,
    output logic [ADDR_W-1:0]  table_ptr
);
    localparam logic [1:0] TT_WALK = 2'd0;
    localparam logic [1:0] TT_PASS = 2'd2;

    logic [QW-1:0] lo, hi;
    logic          rsvd, width_ok, untrans;
    logic [2:0]    lvl;

    // Field extraction and width decode.
    always_comb begin
        lo       = entry[QW-1:0];
        hi       = entry[ENTRY_W-1:QW];
        rsvd     = (|lo[11:4]) || (|hi[7:3]) || (|hi[63:24]);
        untrans  = (atype == 2'd0);
        width_ok = 1'b1;
        case (hi[2:0])
            3'd1:    lvl = 3'd3;
            3'd2:    lvl = 3'd4;
            3'd3:    lvl = 3'd5;
            default: begin lvl = 3'd0; width_ok = 1'b0; end
        endcase
        table_ptr = ADDR_W'({lo[QW-1:PAGE_SH], {PAGE_SH{1'b0}}});
    end

    // Ordered check chain producing the verdict.
    always_comb begin
        verdict.quiet  = lo[1];
        verdict.domain = hi[23:8];
        verdict.levels = lvl;
        verdict.kind   = KIND_FAULT;
        verdict.reason = RSN_NONE;
        if (!lo[0])                                verdict.reason = RSN_CTX_ABSENT;
        else if (rsvd)                             verdict.reason = RSN_CTX_RSVD;
        else if (lo[3:2] == TT_WALK) begin
            if (!untrans)                          verdict.reason = RSN_BLOCKED;
            else if (!width_ok)                    verdict.reason = RSN_BAD_WIDTH;
            else                                   verdict.kind   = KIND_WALK;
        end else if (lo[3:2] == TT_PASS) begin
            if (!pt_en)                            verdict.reason = RSN_BAD_TYPE;
            else if (!untrans)                     verdict.reason = RSN_BLOCKED;
            else if (!width_ok)                    verdict.reason = RSN_BAD_WIDTH;
            else                                   verdict.kind   = KIND_PASS;
        end else                                   verdict.reason = RSN_BAD_TYPE;
    end
endmodule

// File: rtl/ctxres_fault_fmt.sv
// Fault record formatter: packs the held request fields and the reason into the
// two record words. Combinational; assumes a 20-bit PASID.
module ctxres_fault_fmt
    import ctxres_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [SID_W-1:0]   sid,
    input  logic [3:0]         reason,
    input  logic [1:0]         rtype,
    input  logic               exec,
    input  logic               priv,
    input  logic               pasid_v,
    input  logic [PASID_W-1:0] pasid,
    input  logic [ADDR_W-1:0]  addr,
    output logic [QW-1:0]      rec_hi,
    output logic [ADDR_W-1:0]  rec_lo
);
    // Bit packing of both record words.
    always_comb begin
        rec_hi = {1'b1, 14'd0, pasid, pasid_v, priv, exec, rtype[1], rtype[0],
                  4'd0, reason, sid};
        rec_lo = addr & ~ADDR_W'((1 << PAGE_SH) - 1);
    end
endmodule

// File: rtl/ctxres_seq.sv
// Sequencer: accepts one request when idle, issues the root read and then the
// context read, and registers the result. Assumes the memory answers each read
// with exactly one response and that only one read is ever outstanding.
module ctxres_seq
    import ctxres_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SID_W-1:0]   req_sid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [1:0]         req_type,
    input  logic               req_exec,
    input  logic               req_priv,
    input  logic [1:0]         req_atype,
    input  logic               req_pasid_v,
    input  logic [PASID_W-1:0] req_pasid,
    output logic [SID_W-1:0]   sid_q,
    output logic [ADDR_W-1:0]  addr_q,
    output logic [1:0]         type_q,
    output logic               exec_q,
    output logic               priv_q,
    output logic [1:0]         atype_q,
    output logic               pasid_v_q,
    output logic [PASID_W-1:0] pasid_q,
    input  logic [ADDR_W-1:0]  root_addr,
    input  logic [ADDR_W-1:0]  ctx_addr,
    input  logic               root_present,
    input  logic               root_rsvd,
    input  verdict_t           verdict,
    input  logic [ADDR_W-1:0]  table_ptr,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic               res_valid,
    output logic [1:0]         res_kind,
    output logic [3:0]         res_reason,
    output logic [DOM_W-1:0]   res_domain,
    output logic [2:0]         res_levels,
    output logic [ADDR_W-1:0]  res_table,
    output logic [ADDR_W-1:0]  res_addr,
    output logic [LEN_W-1:0]   res_len,
    output logic [2:0]         res_perm,
    output logic               flt_valid
);
    state_e            state;
    logic [ADDR_W-1:0] ctx_addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              quiet_q, ctx_stage_q;
    logic              root_fail;

    // Read-port drive and root-stage outcome.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_ROOT_RD) || (state == ST_CTX_RD);
        mem_req_addr  = (state == ST_CTX_RD) ? ctx_addr_q : root_addr;
        root_fail     = !root_present || root_rsvd;
    end

    // State machine, request latch and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            sid_q       <= '0;
            addr_q      <= '0;
            len_q       <= '0;
            type_q      <= '0;
            exec_q      <= 1'b0;
            priv_q      <= 1'b0;
            atype_q     <= '0;
            pasid_v_q   <= 1'b0;
            pasid_q     <= '0;
            ctx_addr_q  <= '0;
            res_valid   <= 1'b0;
            res_kind    <= '0;
            res_reason  <= '0;
            res_domain  <= '0;
            res_levels  <= '0;
            res_table   <= '0;
            res_addr    <= '0;
            res_len     <= '0;
            res_perm    <= '0;
            flt_valid   <= 1'b0;
            quiet_q     <= 1'b0;
            ctx_stage_q <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            flt_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    sid_q     <= req_sid;
                    addr_q    <= req_addr;
                    len_q     <= req_len;
                    type_q    <= req_type;
                    exec_q    <= req_exec;
                    priv_q    <= req_priv;
                    atype_q   <= req_atype;
                    pasid_v_q <= req_pasid_v;
                    pasid_q   <= req_pasid;
                    state     <= ST_ROOT_RD;
                end
                ST_ROOT_RD: state <= ST_ROOT_WAIT;
                ST_ROOT_WAIT: if (mem_rsp_valid) begin
                    if (root_fail) begin
                        res_valid   <= 1'b1;
                        flt_valid   <= 1'b1;
                        res_kind    <= KIND_FAULT;
                        res_reason  <= root_present ? RSN_ROOT_RSVD : RSN_ROOT_ABSENT;
                        res_perm    <= '0;
                        quiet_q     <= 1'b0;
                        ctx_stage_q <= 1'b0;
                        state       <= ST_IDLE;
                    end else begin
                        ctx_addr_q  <= ctx_addr;
                        state       <= ST_CTX_RD;
                    end
                end
                ST_CTX_RD: state <= ST_CTX_WAIT;
                ST_CTX_WAIT: if (mem_rsp_valid) begin
                    res_valid   <= 1'b1;
                    res_kind    <= verdict.kind;
                    res_reason  <= verdict.reason;
                    res_domain  <= verdict.domain;
                    res_levels  <= verdict.levels;
                    res_table   <= table_ptr;
                    res_addr    <= addr_q & ~ADDR_W'((1 << PAGE_SH) - 1);
                    res_len     <= len_q;
                    res_perm    <= (verdict.kind == KIND_PASS) ? 3'b111 : 3'b000;
                    flt_valid   <= (verdict.kind == KIND_FAULT) && !verdict.quiet;
                    quiet_q     <= verdict.quiet;
                    ctx_stage_q <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_busy_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    assert_no_ctx_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROOT_WAIT && mem_rsp_valid && root_fail) |=> !mem_req_valid);
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_walk_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == KIND_WALK) |-> (res_levels >= 3'd3 && res_levels <= 3'd5));
    assert_fault_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (res_valid && res_kind == KIND_FAULT));
    assert_quiet_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ctx_stage_q && quiet_q) |-> !flt_valid);
endmodule

// File: rtl/ctxres_top.sv
// Top: source-ID context resolver. Wires the sequencer to the root and context
// checkers and the fault record formatter. One request in flight at a time.
module ctxres_top
    import ctxres_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  root_base,
    input  logic               pt_en,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [15:0]        req_sid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [1:0]         req_type,
    input  logic               req_exec,
    input  logic               req_priv,
    input  logic [1:0]         req_atype,
    input  logic               req_pasid_v,
    input  logic [19:0]        req_pasid,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [127:0]       mem_rsp_data,
    output logic               res_valid,
    output logic [1:0]         res_kind,
    output logic [3:0]         res_reason,
    output logic [15:0]        res_domain,
    output logic [2:0]         res_levels,
    output logic [ADDR_W-1:0]  res_table,
    output logic [ADDR_W-1:0]  res_addr,
    output logic [LEN_W-1:0]   res_len,
    output logic [2:0]         res_perm,
    output logic               flt_valid,
    output logic [63:0]        flt_hi,
    output logic [ADDR_W-1:0]  flt_lo
);
    logic [SID_W-1:0]   sid_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [1:0]         type_q, atype_q;
    logic               exec_q, priv_q, pasid_v_q;
    logic [PASID_W-1:0] pasid_q;
    logic [ADDR_W-1:0]  root_addr, ctx_addr, table_ptr;
    logic               root_present, root_rsvd;
    verdict_t           verdict;

    ctxres_root_chk #(.ADDR_W(ADDR_W)) u_root (
        .base(root_base), .sid(sid_q), .entry(mem_rsp_data),
        .root_addr(root_addr), .ctx_addr(ctx_addr),
        .present(root_present), .rsvd_err(root_rsvd));

    ctxres_ctx_chk #(.ADDR_W(ADDR_W)) u_ctx (
        .entry(mem_rsp_data), .atype(atype_q), .pt_en(pt_en),
        .verdict(verdict), .table_ptr(table_ptr));

    ctxres_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_sid(req_sid), .req_addr(req_addr), .req_len(req_len),
        .req_type(req_type), .req_exec(req_exec), .req_priv(req_priv),
        .req_atype(req_atype), .req_pasid_v(req_pasid_v), .req_pasid(req_pasid),
        .sid_q(sid_q), .addr_q(addr_q), .type_q(type_q), .exec_q(exec_q),
        .priv_q(priv_q), .atype_q(atype_q), .pasid_v_q(pasid_v_q), .pasid_q(pasid_q),
        .root_addr(root_addr), .ctx_addr(ctx_addr),
        .root_present(root_present), .root_rsvd(root_rsvd),
        .verdict(verdict), .table_ptr(table_ptr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .res_valid(res_valid), .res_kind(res_kind), .res_reason(res_reason),
        .res_domain(res_domain), .res_levels(res_levels), .res_table(res_table),
        .res_addr(res_addr), .res_len(res_len), .res_perm(res_perm),
        .flt_valid(flt_valid));

    ctxres_fault_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .sid(sid_q), .reason(res_reason), .rtype(type_q), .exec(exec_q),
        .priv(priv_q), .pasid_v(pasid_v_q), .pasid(pasid_q), .addr(addr_q),
        .rec_hi(flt_hi), .rec_lo(flt_lo));
endmodule

// File: tb/sim_ctxres_top.sv
`timescale 1ns/1ps
module sim_ctxres_top;
    typedef struct packed {
        logic [63:0] root_lo;
        logic [63:0] ctx_lo;
        logic [63:0] ctx_hi;
        logic [1:0]  atype;
        logic        pten;
        logic [1:0]  kind;
        logic [3:0]  rsn;
        logic        fv;
        logic [2:0]  lvl;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{64'h20001, 64'h30001, 64'h4202,      2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 3'd4}, // walk, width 2
        '{64'h20001, 64'h30001, 64'h4201,      2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 3'd3}, // width 1
        '{64'h20001, 64'h30001, 64'h4203,      2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 3'd5}, // width 3
        '{64'h20001, 64'h30001, 64'h4200,      2'd0, 1'b0, 2'd2, 4'd6, 1'b1, 3'd0}, // width 0
        '{64'h20001, 64'h30001, 64'h4204,      2'd0, 1'b0, 2'd2, 4'd6, 1'b1, 3'd0}, // width 4
        '{64'h20001, 64'h0,     64'h4202,      2'd0, 1'b0, 2'd2, 4'd3, 1'b1, 3'd0}, // absent
        '{64'h20001, 64'h10,    64'h80,        2'd0, 1'b0, 2'd2, 4'd3, 1'b1, 3'd0}, // absent, rsvd set
        '{64'h20001, 64'h30011, 64'h4202,      2'd0, 1'b0, 2'd2, 4'd4, 1'b1, 3'd0}, // rsvd low
        '{64'h20001, 64'h30001, 64'h01004202,  2'd0, 1'b0, 2'd2, 4'd4, 1'b1, 3'd0}, // rsvd high
        '{64'h20001, 64'h30005, 64'h4202,      2'd0, 1'b0, 2'd2, 4'd5, 1'b1, 3'd0}, // kind 1
        '{64'h20001, 64'h3000D, 64'h4202,      2'd0, 1'b1, 2'd2, 4'd5, 1'b1, 3'd0}, // kind 3
        '{64'h20001, 64'h30009, 64'h4202,      2'd0, 1'b1, 2'd1, 4'd0, 1'b0, 3'd0}, // pass
        '{64'h20001, 64'h30009, 64'h4202,      2'd0, 1'b0, 2'd2, 4'd5, 1'b1, 3'd0}, // pass disabled
        '{64'h20001, 64'h30001, 64'h4202,      2'd2, 1'b0, 2'd2, 4'd7, 1'b1, 3'd0}, // translated
        '{64'h20001, 64'h30009, 64'h4202,      2'd1, 1'b1, 2'd2, 4'd7, 1'b1, 3'd0}, // xlate req
        '{64'h20001, 64'h30003, 64'h4200,      2'd0, 1'b0, 2'd2, 4'd6, 1'b0, 3'd0}, // quiet width
        '{64'h20001, 64'h2,     64'h0,         2'd0, 1'b0, 2'd2, 4'd3, 1'b0, 3'd0}, // quiet absent
        '{64'h0,     64'h30001, 64'h4202,      2'd0, 1'b0, 2'd2, 4'd1, 1'b1, 3'd0}, // root absent
        '{64'h20003, 64'h30001, 64'h4202,      2'd0, 1'b0, 2'd2, 4'd2, 1'b1, 3'd0}, // root rsvd
        '{64'h20001, 64'h30009, 64'h4200,      2'd0, 1'b1, 2'd2, 4'd6, 1'b1, 3'd0}  // pass width 0
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  root_base = 64'h10000;
    logic         pt_en = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_sid = 16'h1234;
    logic [63:0]  req_addr = 64'hAB_CDEF_1234;
    logic [31:0]  req_len = 32'h3000;
    logic [1:0]   req_type = 2'd0;
    logic         req_exec = 1'b0, req_priv = 1'b0;
    logic [1:0]   req_atype = 2'd0;
    logic         req_pasid_v = 1'b0;
    logic [19:0]  req_pasid = '0;
    logic         mem_req_valid;
    logic [63:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic         res_valid, flt_valid;
    logic [1:0]   res_kind;
    logic [3:0]   res_reason;
    logic [15:0]  res_domain;
    logic [2:0]   res_levels, res_perm;
    logic [63:0]  res_table, res_addr, flt_hi, flt_lo;
    logic [31:0]  res_len;

    int tests = 0, fails = 0;
    int rd_count = 0, res_count = 0;
    logic [63:0] rd_log [8];
    logic [127:0] mem [logic [63:0]];
    logic [63:0] pend_addr;
    int pend_cnt = 0;

    ctxres_top u0 (.*);

    always #2.5 clk = ~clk;

    // Memory model: answers each read two cycles after the request.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend_cnt != 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : '0;
            end
        end
        if (mem_req_valid) begin
            pend_addr <= mem_req_addr;
            pend_cnt  <= 2;
            rd_log[rd_count % 8] <= mem_req_addr;
            rd_count  <= rd_count + 1;
        end
    end

    always @(negedge clk) if (res_valid) res_count <= res_count + 1;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_req();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !res_valid; i++) @(negedge clk);
    endtask

    function automatic string tag_of(vec_t v);
        if (v.kind == 2'd0) return "R8";
        if (v.kind == 2'd1) return "R9";
        if (!v.fv) return "R4";
        case (v.rsn)
            4'd1, 4'd2: return "R2";
            4'd3, 4'd4: return "R3";
            4'd5:       return (v.ctx_lo[3:2] == 2'd2) ? "R9" : "R5";
            4'd6:       return "R7";
            default:    return "R6";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R11)
        chk("R11", "reset req_ready", 64'(req_ready), 64'd1);
        chk("R11", "reset res_valid", 64'(res_valid), 64'd0);
        chk("R11", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < NV; k++) begin
            automatic vec_t v = VECS[k];
            automatic int snap;
            automatic string t = tag_of(v);
            mem[64'h10120] = {64'h0, v.root_lo};
            mem[64'h20340] = {v.ctx_hi, v.ctx_lo};
            req_atype = v.atype;
            pt_en = v.pten;
            snap = rd_count;
            run_req();
            chk(t, "res_valid", 64'(res_valid), 64'd1);
            chk(t, "kind", 64'(res_kind), 64'(v.kind));
            chk(t, "flt_valid", 64'(flt_valid), 64'(v.fv));
            if (v.kind == 2'd2) chk(t, "reason", 64'(res_reason), 64'(v.rsn));
            if (v.kind == 2'd0) begin
                chk("R7", "levels", 64'(res_levels), 64'(v.lvl));
                chk("R8", "domain", 64'(res_domain), 64'h42);
                chk("R8", "table", res_table, 64'h30000);
            end
            if (v.kind == 2'd1) begin
                chk("R9", "addr", res_addr, 64'hAB_CDEF_1000);
                chk("R9", "len", 64'(res_len), 64'h3000);
                chk("R9", "perm", 64'(res_perm), 64'd7);
            end
            @(negedge clk);
            chk("R2", "read count", 64'(rd_count - snap),
                (v.kind == 2'd2 && v.rsn <= 4'd2) ? 64'd1 : 64'd2);
        end
        req_atype = 2'd0;
        pt_en = 1'b0;

        // R1: read addresses for another base and source ID
        begin
            automatic int snap = rd_count;
            root_base = 64'h40000;
            req_sid = 16'hA57C;
            mem[64'h40A50] = {64'h0, 64'h50001};
            mem[64'h507C0] = {64'h4202, 64'h30001};
            run_req();
            chk("R1", "root read addr", rd_log[snap % 8], 64'h40A50);
            chk("R1", "ctx read addr", rd_log[(snap + 1) % 8], 64'h507C0);
            chk("R1", "walk kind", 64'(res_kind), 64'd0);
        end

        // R10: fault record layout
        mem[64'h507C0] = {64'h0, 64'h0};
        req_addr = 64'h1234_5678_9ABC;
        req_type = 2'b10;
        req_exec = 1'b1;
        req_priv = 1'b0;
        req_pasid_v = 1'b1;
        req_pasid = 20'h5A5A5;
        run_req();
        chk("R10", "flt_valid", 64'(flt_valid), 64'd1);
        chk("R10", "record hi", flt_hi,
            64'hA57C | (64'd3 << 16) | (64'd1 << 25) | (64'd1 << 26) | (64'd1 << 28)
            | (64'h5A5A5 << 29) | (64'd1 << 63));
        chk("R10", "record lo", flt_lo, 64'h1234_5678_9000);

        // R11: a request raised while busy is ignored
        begin
            automatic int snap_rd, snap_res;
            req_sid = 16'h1234;
            root_base = 64'h10000;
            mem[64'h10120] = {64'h0, 64'h20001};
            mem[64'h20340] = {64'h0, 64'h0};
            req_pasid_v = 1'b0;
            req_type = 2'd0;
            req_exec = 1'b0;
            @(negedge clk);
            snap_rd = rd_count;
            snap_res = res_count;
            req_valid = 1'b1;
            @(negedge clk);
            req_sid = 16'hFFFF;
            chk("R11", "ready low while busy", 64'(req_ready), 64'd0);
            @(negedge clk);
            chk("R11", "ready low while busy 2", 64'(req_ready), 64'd0);
            @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 200 && !res_valid; i++) @(negedge clk);
            chk("R11", "record sid kept", 64'(flt_hi[15:0]), 64'h1234);
            repeat (12) @(negedge clk);
            chk("R11", "single result", 64'(res_count - snap_res), 64'd1);
            chk("R11", "two reads only", 64'(rd_count - snap_rd), 64'd2);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule